// File: doc/BRIEF.md
# Overcurrent Circuit Breaker Controller

This block is the digital sequencer behind an electronic circuit breaker on a power path. Two comparator flags come in. The first says the sense voltage is above the current-limit threshold, while an analog loop regulates the current. The second says the sense voltage is above a much higher threshold that indicates a severe short. The severe-short flag goes straight through to a fast gate pull-down command. The current-limit flag starts a breaker timer. If the flag holds until the timer expires, the controller trips.

A trip turns the FET off with a strong pull-down. It also discharges the soft-start and timer capacitors, resets power-good and records two status bits. One is a one-cycle overcurrent-present flag. The other is a latched overcurrent fault bit, which stays set until it is cleared. After a trip the FET stays off for a cooling delay of four tD periods, and nothing can shorten or restart that delay. When auto-retry is enabled, the cooling delay starts straight away. When auto-retry is disabled, the block first waits for the fault bit to be cleared and only then starts the cooling delay.

The breaker time and tD are parameters, given in clock cycles. The controller states are held in a one-hot register with a synchronous, active-low reset.

Top module: `ocb_ctrl`

## Requirements
- R1: After reset, the outputs are as follows: `gate_en_o`=1, `pulldown_o`=0, `cap_dis_o`=0, `pg_rst_o`=0, `oc_present_o`=0 and `oc_fault_o`=0.
- R2: Counting the clock edge that first samples `ilim_i` high, a trip happens only if `ilim_i` is high for more than BRK_CYCLES consecutive edges. A pulse that covers exactly BRK_CYCLES edges does not trip.
- R3: When `ilim_i` is sampled low before the timer expires, the timer returns to zero and no fault bit is set. A later pulse has to run the full length again.
- R4: In the cycle after the trip edge:
  - `gate_en_o` is 0.
  - `pulldown_o`, `cap_dis_o`, `pg_rst_o`, `oc_present_o` and `oc_fault_o` are all 1.
- R5: `oc_present_o` is high for exactly one cycle and then clears, because the FET is already off. `cap_dis_o` and `pg_rst_o` are also one-cycle pulses.
- R6: With `retry_en_i`=1, the cooling delay starts on the edge after the trip cycle. `gate_en_o` returns exactly 4*TD_CYCLES cycles later. `pulldown_o` stays high until then.
- R7: With `retry_en_i`=0, `gate_en_o` stays 0 for as long as `oc_fault_o` is 1. It returns 1+4*TD_CYCLES edges after the edge that clears the fault.
- R8: During the cooling delay, none of `ilim_i`, `short_i` or `fault_clr_i` changes the number of cycles until `gate_en_o` returns.
- R9: `fast_pd_o` follows `short_i` without a clock delay, in every state.
- R10: A pulse on `fault_clr_i` clears `oc_fault_o` on the next edge. If a trip and a clear fall on the same edge, the trip wins and the bit reads 1.
- R11: `oc_fault_o` stays latched through an automatic retry until it is cleared.
- R12: The controller state register is always one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ilim_i | input | 1 | Current-limit comparator flag |
| short_i | input | 1 | Severe-short comparator flag |
| retry_en_i | input | 1 | 1 = retry automatically after the cooling delay |
| fault_clr_i | input | 1 | Register-write strobe that clears the latched fault bit |
| gate_en_o | output | 1 | FET gate enable |
| pulldown_o | output | 1 | Strong gate pull-down command |
| fast_pd_o | output | 1 | Fast pull-down command for a severe short |
| cap_dis_o | output | 1 | Discharge command for the soft-start and timer capacitors |
| pg_rst_o | output | 1 | Power-good reset |
| oc_present_o | output | 1 | Overcurrent-present status bit |
| oc_fault_o | output | 1 | Latched overcurrent fault bit |

## Verification
Two functions can fall in the same cycle: the hardware setting the fault bit on a trip, and software clearing it with a write. The bench provokes this by holding `fault_clr_i` high through a whole breaker interval, so that the clear strobe lands on the trip edge. It then expects the bit to read 1 right after the trip and 0 one edge later. The cooling delay is also driven while every other input toggles, and it is judged only by the exact cycle in which the gate comes back.

// File: rtl/ocb_pkg.sv
package ocb_pkg;

  typedef enum logic [4:0] {
    ST_IDLE   = 5'b00001,
    ST_TIMING = 5'b00010,
    ST_TRIP   = 5'b00100,
    ST_COOL   = 5'b01000,
    ST_WAIT   = 5'b10000
  } ocb_state_e;

  // cooling span is four tD periods
  function automatic int unsigned cool_span(input int unsigned td);
    return 4 * td;
  endfunction

  // bits needed to count 0 .. lim-1
  function automatic int unsigned span_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim);
  endfunction

endpackage

// File: rtl/ocb_span_cnt.sv
module ocb_span_cnt #(
  parameter int unsigned LIM = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned W = ocb_pkg::span_width(LIM);
  localparam logic [W-1:0] LAST = W'(LIM - 1);

  logic [W-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || done)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ocb_oc_status.sv
module ocb_oc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic clr,
  output logic present,
  output logic fault
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      present <= 1'b0;
      fault   <= 1'b0;
    end else begin
      present <= trip;
      if (trip)     fault <= 1'b1;
      else if (clr) fault <= 1'b0;
    end
  end
endmodule

// File: rtl/ocb_ctrl.sv
module ocb_ctrl #(
  parameter int unsigned BRK_CYCLES = 66250,
  parameter int unsigned TD_CYCLES  = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ilim_i,
  input  logic short_i,
  input  logic retry_en_i,
  input  logic fault_clr_i,
  output logic gate_en_o,
  output logic pulldown_o,
  output logic fast_pd_o,
  output logic cap_dis_o,
  output logic pg_rst_o,
  output logic oc_present_o,
  output logic oc_fault_o
);
  import ocb_pkg::*;

  localparam int unsigned COOL_CYCLES = cool_span(TD_CYCLES);

  ocb_state_e state_q, state_d;
  logic brk_run, brk_done, trip_evt;
  logic cool_run, cool_done;

  assign brk_run  = (state_q == ST_TIMING) && ilim_i;
  assign trip_evt = brk_done;
  assign cool_run = (state_q == ST_COOL);

  ocb_span_cnt #(.LIM(BRK_CYCLES)) u_brk (
    .clk(clk), .rst_n(rst_n), .run(brk_run), .done(brk_done)
  );

  ocb_span_cnt #(.LIM(COOL_CYCLES)) u_cool (
    .clk(clk), .rst_n(rst_n), .run(cool_run), .done(cool_done)
  );

  ocb_oc_status u_stat (
    .clk(clk), .rst_n(rst_n), .trip(trip_evt), .clr(fault_clr_i),
    .present(oc_present_o), .fault(oc_fault_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (ilim_i) state_d = ST_TIMING;
      ST_TIMING: begin
        if (!ilim_i)       state_d = ST_IDLE;
        else if (trip_evt) state_d = ST_TRIP;
      end
      ST_TRIP:   state_d = retry_en_i ? ST_COOL : ST_WAIT;
      ST_COOL:   if (cool_done) state_d = ST_IDLE;
      ST_WAIT:   if (!oc_fault_o) state_d = ST_COOL;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign gate_en_o  = (state_q == ST_IDLE) || (state_q == ST_TIMING);
  assign pulldown_o = (state_q == ST_TRIP) || (state_q == ST_COOL) || (state_q == ST_WAIT);
  assign cap_dis_o  = (state_q == ST_TRIP);
  assign pg_rst_o   = (state_q == ST_TRIP);
  assign fast_pd_o  = short_i;

endmodule

// File: rtl/ocb_ctrl_chk.sv
module ocb_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ilim_i,
  input logic [4:0] state_q,
  input logic       trip_evt,
  input logic       cool_done,
  input logic       gate_en_o,
  input logic       pulldown_o,
  input logic       oc_present_o,
  input logic       oc_fault_o
);
  localparam logic [4:0] S_IDLE   = 5'b00001;
  localparam logic [4:0] S_TIMING = 5'b00010;
  localparam logic [4:0] S_COOL   = 5'b01000;
  localparam logic [4:0] S_WAIT   = 5'b10000;

  // R12
  onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(state_q));

  // R3
  early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_TIMING && !ilim_i) |=> (state_q == S_IDLE));

  // R4
  trip_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt |=> (!gate_en_o && pulldown_o && oc_present_o));

  // R5
  present_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_present_o |=> !oc_present_o);

  // R10
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt |=> oc_fault_o);

  // R8
  cool_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_COOL && !cool_done) |=> (state_q == S_COOL));

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && oc_fault_o) |=> (state_q == S_WAIT));

  // R6
  cool_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_COOL && cool_done) |=> (state_q == S_IDLE && gate_en_o));
endmodule

bind ocb_ctrl ocb_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ilim_i(ilim_i), .state_q(state_q),
  .trip_evt(trip_evt), .cool_done(cool_done), .gate_en_o(gate_en_o),
  .pulldown_o(pulldown_o), .oc_present_o(oc_present_o), .oc_fault_o(oc_fault_o)
);

// File: tb/tb_ocb_ctrl.sv
module tb_ocb_ctrl;
  localparam int BRK  = 8;
  localparam int TD   = 3;
  localparam int COOL = 4 * TD;

  logic clk = 1'b0;
  logic rst_n, ilim, shrt, retry, fclr;
  logic gate, pd, fpd, cdis, pgr, pres, flt;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ocb_ctrl #(.BRK_CYCLES(BRK), .TD_CYCLES(TD)) dut (
    .clk(clk), .rst_n(rst_n), .ilim_i(ilim), .short_i(shrt),
    .retry_en_i(retry), .fault_clr_i(fclr), .gate_en_o(gate),
    .pulldown_o(pd), .fast_pd_o(fpd), .cap_dis_o(cdis), .pg_rst_o(pgr),
    .oc_present_o(pres), .oc_fault_o(flt)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic a, input logic e);
    chk(a === e, req, int'(a), int'(e));
  endtask

  initial begin
    #(8 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ilim = 1'b0; shrt = 1'b0; retry = 1'b1; fclr = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    eq("R1 gate", gate, 1'b1);   eq("R1 pulldown", pd, 1'b0);
    eq("R1 capdis", cdis, 1'b0); eq("R1 pgrst", pgr, 1'b0);
    eq("R1 present", pres, 1'b0); eq("R1 fault", flt, 1'b0);

    // R9 fast pulldown in idle
    shrt = 1'b1; #1 eq("R9 idle high", fpd, 1'b1);
    shrt = 1'b0; #1 eq("R9 idle low", fpd, 1'b0);

    // R2/R3 sweep of pulse lengths that must not trip
    for (int len = 1; len <= BRK; len++) begin
      ilim = 1'b1;
      repeat (len) tick();
      eq("R2 gate during pulse", gate, 1'b1);
      ilim = 1'b0;
      tick(); tick();
      eq("R3 no fault short pulse", flt, 1'b0);
      eq("R3 no present short pulse", pres, 1'b0);
    end

    // R3 two back-to-back pulses of BRK edges separated by one low edge
    ilim = 1'b1; repeat (BRK) tick();
    ilim = 1'b0; tick();
    ilim = 1'b1; repeat (BRK) tick();
    ilim = 1'b0; tick(); tick();
    eq("R3 timer restarted", flt, 1'b0);

    // R2/R4/R5/R6/R11 trip with auto-retry
    ilim = 1'b1;
    repeat (BRK) tick();
    eq("R2 not yet tripped", gate, 1'b1);
    tick();
    ilim = 1'b0;
    eq("R4 gate off", gate, 1'b0);  eq("R4 pulldown", pd, 1'b1);
    eq("R4 capdis", cdis, 1'b1);    eq("R4 pgrst", pgr, 1'b1);
    eq("R4 present", pres, 1'b1);   eq("R4 fault", flt, 1'b1);
    tick();
    eq("R5 present cleared", pres, 1'b0);
    eq("R5 capdis pulse", cdis, 1'b0);
    eq("R5 pgrst pulse", pgr, 1'b0);
    eq("R6 pulldown held", pd, 1'b1);
    repeat (COOL - 1) tick();
    eq("R6 still cooling", gate, 1'b0);
    tick();
    eq("R6 retry gate on", gate, 1'b1);
    eq("R6 pulldown released", pd, 1'b0);
    eq("R11 fault latched", flt, 1'b1);
    fclr = 1'b1; tick(); fclr = 1'b0;
    eq("R10 clear works", flt, 1'b0);

    // R7 no auto-retry
    retry = 1'b0;
    ilim = 1'b1; repeat (BRK + 1) tick(); ilim = 1'b0;
    eq("R7 tripped", gate, 1'b0);
    repeat (20) tick();
    eq("R7 held off", gate, 1'b0);
    eq("R7 fault held", flt, 1'b1);
    fclr = 1'b1; tick(); fclr = 1'b0;
    eq("R7 fault cleared", flt, 1'b0);
    eq("R7 gate still off", gate, 1'b0);
    repeat (COOL) tick();
    eq("R7 cooling after clear", gate, 1'b0);
    tick();
    eq("R7 gate on after clear", gate, 1'b1);

    // R8/R9 cooling with all other inputs toggling
    retry = 1'b1;
    ilim = 1'b1; repeat (BRK + 1) tick();
    tick();
    for (int i = 0; i < COOL - 1; i++) begin
      shrt = i[0];
      fclr = i[1];
      #1 eq("R9 fast pd in cool", fpd, shrt);
      tick();
      eq("R8 cool uninterrupted", gate, 1'b0);
    end
    shrt = 1'b0; fclr = 1'b0;
    tick();
    eq("R8 cool exact length", gate, 1'b1);
    ilim = 1'b0;
    tick();
    fclr = 1'b1; tick(); fclr = 1'b0;

    // R10 trip and clear on the same edge
    fclr = 1'b1;
    ilim = 1'b1; repeat (BRK + 1) tick(); ilim = 1'b0;
    eq("R10 set wins", flt, 1'b1);
    tick();
    eq("R10 clear next edge", flt, 1'b0);
    fclr = 1'b0;
    repeat (COOL + 2) tick();
    eq("R6 recovered", gate, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule